// File: doc/BRIEF.md
# Magic-Word Service Watchdog

This block is a watchdog peripheral with a small 32-bit register port on the system clock. It counts a separate watchdog clock. Software sets a run bit and a 5-bit power-of-two delay selector. While the watchdog is running, software must service it in time. A service is two writes of fixed key words, in order, to two different registers. If no service arrives before the period runs out, or if a service sequence is wrong, the block raises a reset request. The request is a pulse of fixed length that goes to the system reset controller.

The block keeps the cause of the most recent reset in a 3-bit field that software reads back. That field and the request pulse are cleared only by a separate power-on reset, so the field still holds its value after the system reset that the watchdog itself requests. Turning the run bit off does not stop the counter at once. The counter stops only after the next valid two-word service.

The block has three further inputs. A soft-reset register raises a request whenever it is written. A user-reset event input only records its cause. Configuration and service events cross into the watchdog clock domain through two-flop synchronizers and a toggle handshake, and the expiry event crosses back the same way. The system reset and the watchdog-domain reset are meant to be released together.

Top module: `magic_watchdog`

## Requirements
- R1: After power-on reset the cause field reads 0 (hard reset) and `rst_req` is low. After system reset the configuration register reads 0 and the watchdog is stopped.
- R2: The configuration register at byte offset 0x04 holds the run enable in bit 31 and the delay selector d in bits 4:0. A read of 0x04 returns both fields, and all other bits read 0.
- R3: When the watchdog is running, the request pulse starts 2^(d+1) watchdog clock cycles after the count was last restarted, plus synchronizer latency, and the cause field becomes 1 (timeout). The count starts over after each expiry.
- R4: A valid service is 0xABCD1234 written to offset 0x08 followed by 0x4321DCBA written to offset 0x0C. It restarts the count and raises no request.
- R5: Each of the following raises a request and sets the cause field to 2 (incorrect service): a wrong word written to 0x08 or 0x0C; a write to 0x0C that does not directly follow a correct write to 0x08; a second write to 0x08 while a first word is already pending. Any write to another offset between the two service writes also makes the sequence wrong.
- R6: Writing 0 to the run enable does not stop the count. The watchdog stops only when the next valid service completes.
- R7: A write that changes the delay selector restarts the count from zero.
- R8: Any write to offset 0x00, whatever its data, raises a request and sets the cause field to 3 (soft reset).
- R9: A one-cycle pulse on `user_rst_evt` sets the cause field to 4 (user reset) and raises no request.
- R10: The `rst_req` output goes high in the system clock cycle that follows the triggering write. It stays high for exactly PULSE_LEN (16) system clocks.
- R11: The cause field reads back in bits 2:0 of offset 0x08, with all other bits 0. It keeps its value through a system reset and is cleared only by `por_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the register port, cause field and request pulse |
| sys_rst_n | input | 1 | Active-low system reset for the configuration and service state |
| por_n | input | 1 | Active-low power-on reset for the cause field and the request pulse |
| wdt_clk | input | 1 | Watchdog count clock |
| wdt_rst_n | input | 1 | Active-low reset for the watchdog clock domain |
| reg_wr | input | 1 | Write strobe, one write per asserted cycle |
| reg_addr | input | 4 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| user_rst_evt | input | 1 | Pulse that records a user-initiated reset as the cause |
| rst_req | output | 1 | Reset request pulse to the system reset controller |

## Verification
If the pending-first-word flag is wrong, it shows at `rst_req` on the very next write to 0x08 or 0x0C. A valid sequence then raises a false request, or a broken sequence raises none, and the cause field reads back the wrong code one cycle later. A fault in the count, the restart or the deferred-stop logic has no immediate effect. It appears only over a full period: a request fires while servicing is regular, or fails to fire after servicing stops. For that reason the bench observes whole windows of many watchdog periods. A wrong cause field or pulse length can be read at the ports after every event.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
   localparam int REG_AW = 4;

   localparam logic [REG_AW-1:0] OFS_SOFT = 4'h0;
   localparam logic [REG_AW-1:0] OFS_CFG  = 4'h4;
   localparam logic [REG_AW-1:0] OFS_KEYA = 4'h8;
   localparam logic [REG_AW-1:0] OFS_KEYB = 4'hC;

   localparam logic [31:0] KEY_FIRST  = 32'hABCD_1234;
   localparam logic [31:0] KEY_SECOND = 32'h4321_DCBA;

   localparam int RUN_BIT = 31;

   typedef enum logic [2:0] {
      CAUSE_HARD    = 3'd0,
      CAUSE_EXPIRED = 3'd1,
      CAUSE_BAD_SVC = 3'd2,
      CAUSE_SOFT    = 3'd3,
      CAUSE_USER    = 3'd4
   } cause_e;
endpackage

// File: rtl/mwd_sync.sv
// Multi-stage flop synchronizer; the stage count is a parameter.
module mwd_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] q_r;
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_r <= '0;
            else        q_r <= d;
         end
      end else begin : g_rest
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_r <= '0;
            else        q_r <= g_stage[s-1].q_r;
         end
      end
   end

   assign q = g_stage[STAGES-1].q_r;
endmodule

// File: rtl/mwd_pulse.sv
// Fixed-length request pulse; a new trigger reloads the full length.
module mwd_pulse #(
   parameter int LEN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic req
);
   localparam int CW = $clog2(LEN + 1);
   localparam int SW = $clog2(LEN + 2);

   logic [CW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              left_q <= '0;
      else if (fire)           left_q <= CW'(LEN);
      else if (left_q != '0)   left_q <= left_q - 1'b1;
   end

   assign req = (left_q != '0);

   // checker: cycles since the last trigger, saturating
   logic [SW-1:0] since_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       since_q <= SW'(LEN + 1);
      else if (fire)                    since_q <= '0;
      else if (since_q != SW'(LEN + 1)) since_q <= since_q + 1'b1;
   end

   assert_pulse_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> req);
   assert_pulse_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req) |-> since_q == SW'(LEN));
endmodule

// File: rtl/mwd_counter.sv
// Watchdog-domain period counter: 2^(d+1) cycles from each restart.
module mwd_counter #(
   parameter int DELAY_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_i,
   input  logic [DELAY_W-1:0] delay_i,
   input  logic               kick_i,
   output logic               expire_o
);
   localparam int CNT_W = (1 << DELAY_W) + 1;

   logic [CNT_W-1:0]   cnt_q;
   logic [CNT_W-1:0]   limit;
   logic [DELAY_W:0]   shamt;
   logic [DELAY_W-1:0] delay_q;
   logic               expire_q;
   logic               restart;

   assign shamt   = {1'b0, delay_i} + 1'b1;
   assign limit   = (CNT_W'(1) << shamt) - 1'b1;
   assign restart = !run_i || kick_i || (delay_i != delay_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         delay_q  <= '0;
         expire_q <= 1'b0;
      end else begin
         delay_q  <= delay_i;
         expire_q <= 1'b0;
         if (restart) begin
            cnt_q <= '0;
         end else if (cnt_q == limit) begin
            cnt_q    <= '0;
            expire_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign expire_o = expire_q;

   assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (delay_i == delay_q) |-> cnt_q <= limit);
   assert_expire_running_R3: assert property (@(posedge clk) disable iff (!rst_n)
      expire_q |-> $past(run_i));
endmodule

// File: rtl/mwd_regs.sv
// System-domain register file, service checker and cause field.
module mwd_regs
   import mwd_pkg::*;
#(
   parameter int DELAY_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               por_n,
   input  logic               wr,
   input  logic [REG_AW-1:0]  addr,
   input  logic [31:0]        wdata,
   output logic [31:0]        rdata,
   input  logic               expired_i,
   input  logic               user_i,
   output logic               run_o,
   output logic [DELAY_W-1:0] delay_o,
   output logic               kick_tgl_o,
   output logic               fire_o
);
   logic               cfg_en_q;
   logic [DELAY_W-1:0] cfg_dly_q;
   logic               run_q;
   logic               armed_q;
   logic               kick_tgl_q;
   cause_e             cause_q;

   logic hit_soft, hit_cfg, hit_keya, hit_keyb;
   logic svc_ok, svc_bad;

   assign hit_soft = wr && (addr == OFS_SOFT);
   assign hit_cfg  = wr && (addr == OFS_CFG);
   assign hit_keya = wr && (addr == OFS_KEYA);
   assign hit_keyb = wr && (addr == OFS_KEYB);

   always_comb begin
      svc_ok  = hit_keyb && armed_q && (wdata == KEY_SECOND);
      svc_bad = (hit_keya && (armed_q || (wdata != KEY_FIRST)))
             || (hit_keyb && !svc_ok);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_en_q   <= 1'b0;
         cfg_dly_q  <= '0;
         run_q      <= 1'b0;
         armed_q    <= 1'b0;
         kick_tgl_q <= 1'b0;
      end else begin
         if (hit_cfg) begin
            cfg_en_q  <= wdata[RUN_BIT];
            cfg_dly_q <= wdata[DELAY_W-1:0];
         end
         if (wr) armed_q <= hit_keya && !svc_bad;
         if (hit_cfg && wdata[RUN_BIT])  run_q <= 1'b1;
         else if (svc_ok && !cfg_en_q)   run_q <= 1'b0;
         if (svc_ok) kick_tgl_q <= ~kick_tgl_q;
      end
   end

   // cause field lives in the power-on domain
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)         cause_q <= CAUSE_HARD;
      else if (expired_i) cause_q <= CAUSE_EXPIRED;
      else if (svc_bad)   cause_q <= CAUSE_BAD_SVC;
      else if (hit_soft)  cause_q <= CAUSE_SOFT;
      else if (user_i)    cause_q <= CAUSE_USER;
   end

   always_comb begin
      rdata = '0;
      case (addr)
         OFS_CFG: begin
            rdata[RUN_BIT]       = cfg_en_q;
            rdata[DELAY_W-1:0]   = cfg_dly_q;
         end
         OFS_KEYA: rdata[2:0] = cause_q;
         default:  rdata = '0;
      endcase
   end

   assign run_o      = run_q;
   assign delay_o    = cfg_dly_q;
   assign kick_tgl_o = kick_tgl_q;
   assign fire_o     = hit_soft || svc_bad || expired_i;

   assert_bad_cause_R5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      (svc_bad && !expired_i) |=> cause_q == CAUSE_BAD_SVC);
   assert_soft_cause_R8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      (hit_soft && !expired_i) |=> cause_q == CAUSE_SOFT);
   assert_deferred_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_ok && !cfg_en_q) |=> !run_q);
   assert_arm_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed_q) |-> $past(hit_keya));
   assert_cause_hold_R11: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      !(expired_i || svc_bad || hit_soft || user_i) |=> $stable(cause_q));
endmodule

// File: rtl/magic_watchdog.sv
module magic_watchdog
   import mwd_pkg::*;
#(
   parameter int DELAY_W     = 5,
   parameter int PULSE_LEN   = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic        sys_clk,
   input  logic        sys_rst_n,
   input  logic        por_n,
   input  logic        wdt_clk,
   input  logic        wdt_rst_n,
   input  logic        reg_wr,
   input  logic [3:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic        user_rst_evt,
   output logic        rst_req
);
   localparam int CFG_W = DELAY_W + 1;

   if (DELAY_W < 1 || DELAY_W > 5) begin : g_bad_delay_w
      $fatal(1, "DELAY_W must lie in 1..5");
   end
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $fatal(1, "SYNC_STAGES must be at least 2");
   end
   if (PULSE_LEN < 1) begin : g_bad_pulse
      $fatal(1, "PULSE_LEN must be at least 1");
   end

   logic               run_s, kick_tgl_s, fire_s, expired_s;
   logic [DELAY_W-1:0] dly_s;
   logic               run_w, kick_tgl_w, kick_prev_w, kick_w;
   logic [DELAY_W-1:0] dly_w;
   logic               expire_w, exp_tgl_w;
   logic               exp_tgl_s, exp_prev_s;

   mwd_regs #(.DELAY_W(DELAY_W)) u_regs (
      .clk        (sys_clk),
      .rst_n      (sys_rst_n),
      .por_n      (por_n),
      .wr         (reg_wr),
      .addr       (reg_addr),
      .wdata      (reg_wdata),
      .rdata      (reg_rdata),
      .expired_i  (expired_s),
      .user_i     (user_rst_evt),
      .run_o      (run_s),
      .delay_o    (dly_s),
      .kick_tgl_o (kick_tgl_s),
      .fire_o     (fire_s)
   );

   // system -> watchdog domain
   mwd_sync #(.WIDTH(CFG_W), .STAGES(SYNC_STAGES)) u_cfg_sync (
      .clk   (wdt_clk),
      .rst_n (wdt_rst_n),
      .d     ({run_s, dly_s}),
      .q     ({run_w, dly_w})
   );

   mwd_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_kick_sync (
      .clk   (wdt_clk),
      .rst_n (wdt_rst_n),
      .d     (kick_tgl_s),
      .q     (kick_tgl_w)
   );

   always_ff @(posedge wdt_clk or negedge wdt_rst_n) begin
      if (!wdt_rst_n) kick_prev_w <= 1'b0;
      else            kick_prev_w <= kick_tgl_w;
   end
   assign kick_w = kick_tgl_w ^ kick_prev_w;

   mwd_counter #(.DELAY_W(DELAY_W)) u_count (
      .clk      (wdt_clk),
      .rst_n    (wdt_rst_n),
      .run_i    (run_w),
      .delay_i  (dly_w),
      .kick_i   (kick_w),
      .expire_o (expire_w)
   );

   always_ff @(posedge wdt_clk or negedge wdt_rst_n) begin
      if (!wdt_rst_n)    exp_tgl_w <= 1'b0;
      else if (expire_w) exp_tgl_w <= ~exp_tgl_w;
   end

   // watchdog -> system domain
   mwd_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_exp_sync (
      .clk   (sys_clk),
      .rst_n (sys_rst_n),
      .d     (exp_tgl_w),
      .q     (exp_tgl_s)
   );

   always_ff @(posedge sys_clk or negedge sys_rst_n) begin
      if (!sys_rst_n) exp_prev_s <= 1'b0;
      else            exp_prev_s <= exp_tgl_s;
   end
   assign expired_s = exp_tgl_s ^ exp_prev_s;

   mwd_pulse #(.LEN(PULSE_LEN)) u_pulse (
      .clk   (sys_clk),
      .rst_n (por_n),
      .fire  (fire_s),
      .req   (rst_req)
   );
endmodule

// File: tb/sim_magic_watchdog.sv
module sim_magic_watchdog;
   localparam logic [31:0] K1 = 32'hABCD_1234;
   localparam logic [31:0] K2 = 32'h4321_DCBA;
   localparam int PLEN = 16;

   logic        sys_clk = 1'b0, wdt_clk = 1'b0;
   logic        sys_rst_n = 1'b0, por_n = 1'b0, wdt_rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = 4'h0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        user_rst_evt = 1'b0;
   logic        rst_req;

   int checks = 0, errors = 0;
   int pulses = 0, run_len = 0, last_width = 0;
   logic req_prev = 1'b0;

   always #4 sys_clk = ~sys_clk;    // 125 MHz
   always #13 wdt_clk = ~wdt_clk;

   magic_watchdog u0 (
      .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .por_n(por_n),
      .wdt_clk(wdt_clk), .wdt_rst_n(wdt_rst_n),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .user_rst_evt(user_rst_evt), .rst_req(rst_req)
   );

   always @(negedge sys_clk) begin
      if (rst_req) run_len++;
      else if (run_len != 0) begin last_width = run_len; run_len = 0; end
      if (rst_req && !req_prev) pulses++;
      req_prev = rst_req;
   end

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge sys_clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge sys_clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge sys_clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic service();
      wr(4'h8, K1);
      wr(4'hC, K2);
   endtask

   task automatic wdt_wait(input int n);
      repeat (n) @(posedge wdt_clk);
   endtask

   function automatic logic [31:0] cfg_word(input bit en, input int d);
      return {en, 26'b0, 5'(d)};
   endfunction

   function automatic logic [2:0] exp_cause(input int kind, input logic [2:0] prev);
      case (kind)
         4: return 3'd3;
         5: return 3'd4;
         6: return prev;
         default: return 3'd2;
      endcase
   endfunction

   function automatic bit exp_pulse(input int kind);
      return !(kind == 5 || kind == 6);
   endfunction

   initial begin
      #1000000;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic [2:0]  cause;
      int p0;
      void'($urandom(32'd20240611));

      repeat (5) @(negedge sys_clk);
      por_n = 1'b1; sys_rst_n = 1'b1; wdt_rst_n = 1'b1;
      repeat (3) @(negedge sys_clk);

      // R1 reset state
      check(rst_req == 1'b0, "R1 rst_req after reset", rst_req, 0);
      rd(4'h8, v);
      check(v == 32'd0, "R1/R11 cause after power-on", v, 0);
      rd(4'h4, v);
      check(v == 32'd0, "R1 config after reset", v, 0);

      // R2 config readback, random delays with run bit clear
      for (int i = 0; i < 8; i++) begin
         int d = $urandom_range(31, 0);
         wr(4'h4, cfg_word(1'b0, d) | 32'h0000_0F00);
         rd(4'h4, v);
         check(v == cfg_word(1'b0, d), "R2 config readback", v, cfg_word(1'b0, d));
      end

      // R3 timeout with d=3 (16 watchdog cycles)
      wr(4'h4, cfg_word(1'b1, 3));
      rd(4'h4, v);
      check(v == cfg_word(1'b1, 3), "R2 run bit readback", v, cfg_word(1'b1, 3));
      p0 = pulses;
      wdt_wait(14);
      check(pulses == p0, "R3 no early expiry", pulses - p0, 0);
      wdt_wait(10);
      check(pulses == p0 + 1, "R3 expiry within window", pulses - p0, 1);
      repeat (20) @(negedge sys_clk);
      check(last_width == PLEN, "R10 timeout pulse width", last_width, PLEN);
      rd(4'h8, v);
      check(v == 32'd1, "R3 cause timeout", v, 1);

      // R6 clearing run bit alone does not stop
      wr(4'h4, cfg_word(1'b0, 3));
      p0 = pulses;
      wdt_wait(40);
      check(pulses > p0, "R6 still running after clear", pulses - p0, 1);
      service();
      wdt_wait(10);
      p0 = pulses;
      wdt_wait(60);
      check(pulses == p0, "R6 stopped after service", pulses - p0, 0);

      // R4 regular service keeps it quiet
      wr(4'h4, cfg_word(1'b1, 3));
      p0 = pulses;
      for (int i = 0; i < 20; i++) begin
         wdt_wait(8);
         service();
      end
      check(pulses == p0, "R4 no request with service", pulses - p0, 0);
      wdt_wait(30);
      check(pulses > p0, "R4 expiry once service stops", pulses - p0, 1);
      wr(4'h4, cfg_word(1'b0, 3));
      service();
      wdt_wait(10);

      // R7 delay change restarts the count
      wr(4'h4, cfg_word(1'b1, 4));
      p0 = pulses;
      for (int i = 0; i < 10; i++) begin
         wdt_wait(20);
         wr(4'h4, cfg_word(1'b1, (i % 2 == 0) ? 5 : 4));
      end
      check(pulses == p0, "R7 restarts on delay change", pulses - p0, 0);
      wr(4'h4, cfg_word(1'b0, 4));
      service();
      wdt_wait(10);
      repeat (30) @(negedge sys_clk);

      // R5 R8 R9 R10 random event mix, watchdog stopped
      rd(4'h8, v);
      cause = v[2:0];
      for (int i = 0; i < 32; i++) begin
         int kind = $urandom_range(7, 0);
         logic [31:0] bad;
         logic [2:0] ec;
         p0 = pulses;
         case (kind)
            0: begin
               do bad = $urandom; while (bad == K1);
               wr(4'h8, bad);
            end
            1: wr(4'hC, ($urandom_range(1, 0) == 1) ? K2 : $urandom);
            2: begin wr(4'h8, K1); wr(4'h8, K1); end
            3: begin
               do bad = $urandom; while (bad == K2);
               wr(4'h8, K1); wr(4'hC, bad);
            end
            4: wr(4'h0, $urandom);
            5: begin
               @(negedge sys_clk); user_rst_evt = 1'b1;
               @(negedge sys_clk); user_rst_evt = 1'b0;
            end
            6: service();
            default: begin wr(4'h8, K1); wr(4'h4, 32'd0); wr(4'hC, K2); end
         endcase
         check(rst_req == exp_pulse(kind), "R10 request right after event", rst_req, exp_pulse(kind));
         ec = exp_cause(kind, cause);
         rd(4'h8, v);
         check(v == {29'd0, ec}, (kind == 4) ? "R8 soft cause" : (kind == 5) ? "R9 user cause" : "R5 service cause", v, ec);
         cause = ec;
         repeat (24) @(negedge sys_clk);
         check(pulses - p0 == int'(exp_pulse(kind)), "R5 request count", pulses - p0, exp_pulse(kind));
         if (exp_pulse(kind))
            check(last_width == PLEN, "R10 pulse width", last_width, PLEN);
      end

      // R11 cause survives system reset, cleared by power-on reset
      wr(4'h0, 32'h5A5A_5A5A);
      repeat (24) @(negedge sys_clk);
      sys_rst_n = 1'b0; wdt_rst_n = 1'b0;
      repeat (4) @(negedge sys_clk);
      sys_rst_n = 1'b1; wdt_rst_n = 1'b1;
      repeat (4) @(negedge sys_clk);
      rd(4'h8, v);
      check(v == 32'd3, "R11 cause kept through system reset", v, 3);
      rd(4'h4, v);
      check(v == 32'd0, "R1 config cleared by system reset", v, 0);
      por_n = 1'b0;
      repeat (3) @(negedge sys_clk);
      por_n = 1'b1;
      repeat (2) @(negedge sys_clk);
      rd(4'h8, v);
      check(v == 32'd0, "R11 cause cleared by power-on", v, 0);
      check(rst_req == 1'b0, "R1 request low after power-on", rst_req, 0);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule